// File: doc/BRIEF.md
# Macroblock Assembler with Chroma Upsampling

This block sits after the inverse transform in a still-image or video decoder. Decoded 8x8 sample blocks arrive on a valid/ready stream, one sample per transfer. The block collects the blocks of one macroblock in an internal store and then streams the macroblock out as pixels in row-major order.

A two-bit format input picks the operating mode. In colour mode a macroblock is six blocks: two chroma blocks, then four luma quadrants. The output is 256 pixels, each carrying a luma value and the two chroma values. Chroma is read at half resolution in both directions, so one chroma sample serves a 2x2 group of luma pixels. In monochrome mode every block is luma only. It is passed out as 64 pixels, and the chroma outputs are zero.

Input is refused while a macroblock drains, and output stays idle while a macroblock fills. A block-start marker on the input lets an upstream stage realign the sample count inside a block.

Top module: `mbAssembler`

## Requirements
- R1: After a synchronous reset, `inReady` is 1, `outValid` is 0 and `outLast` is 0. The next accepted sample is sample 0 of the first block of a macroblock. That block is Cr in colour mode and luma in monochrome mode.
- R2: `fmtSel` is encoded as 0 = 4 bpp and 1 = 8 bpp (both monochrome), and 2 = 15 bpp and 3 = 24 bpp (both colour). The mode is taken from `fmtSel` on the first accepted sample of a macroblock. A change of `fmtSel` later in the same macroblock has no effect on it.
- R3: In colour mode the block accepts 6 x 64 samples in the block order Cr, Cb, Y1, Y2, Y3, Y4. Within a block, sample s is row s/8, column s%8. `outValid` stays 0 until the last of the 384 samples is accepted, and from then until the macroblock has drained `inReady` is 0.
- R4: In colour mode, output pixel n (0..255) lies at row n/16, column n%16 of the macroblock. Y1 covers the top-left quadrant, Y2 the top-right, Y3 the bottom-left and Y4 the bottom-right. `outY` carries the luma sample at that position.
- R5: In colour mode, the pixel at column x, row y carries on `outCr` and `outCb` the chroma samples with index (y/2)*8 + x/2 of the Cr and Cb blocks.
- R6: In monochrome mode the block accepts 64 samples and then emits 64 pixels. Pixel n carries sample n on `outY`, and `outCb` and `outCr` are 0.
- R7: `outLast` is 1 only on the final pixel of a macroblock: pixel 255 in colour mode and pixel 63 in monochrome mode.
- R8: A pixel advances only on a cycle with `outValid` and `outReady` both 1. While `outReady` is 0 the pixel outputs hold steady. After the final pixel is taken, `inReady` returns to 1 in the next cycle.
- R9: An accepted sample with `inFirst` 1 is stored as sample 0 of the current block, which discards any earlier samples of that block. The samples after it continue at index 1.
- R10: A reset in the middle of a macroblock discards the samples collected so far. The next macroblock is assembled from fresh input only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fmtSel | input | 2 | Output format select (0/1 monochrome, 2/3 colour) |
| inValid | input | 1 | Input sample valid |
| inReady | output | 1 | Input sample accepted when high with `inValid` |
| inFirst | input | 1 | Marks the sample as the first of a block |
| inData | input | 8 | Input sample, two's complement |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Downstream accepts the pixel |
| outLast | output | 1 | Final pixel of the macroblock |
| outY | output | 8 | Luma of the current pixel |
| outCb | output | 8 | Blue-difference chroma of the current pixel |
| outCr | output | 8 | Red-difference chroma of the current pixel |

## Verification
A wrong block or sample counter writes samples to the wrong quadrant or the wrong chroma plane. This shows at the ports as luma or chroma values taken from a wrong position, within the first macroblock drained after the fault. A wrong mode latch or wrong end-of-block logic shows up earlier and more plainly. `outValid` rises before all samples are in, or too late, or `outLast` falls on the wrong pixel count. Every pixel of every drained macroblock is compared against a value derived from its row and column, so a single misplaced sample is caught within that macroblock.

// File: rtl/mbPkg.sv
package mbPkg;

  // log2 of the block edge; blocks are square
  localparam int LOG_BLK     = 3;
  localparam int BLK_SMP_W   = 2 * LOG_BLK;          // sample index width within a block
  localparam int PIX_W       = BLK_SMP_W + 2;         // pixel index width within a macroblock
  localparam int BLK_SAMPLES = 1 << BLK_SMP_W;
  localparam int MB_PIXELS   = 1 << PIX_W;
  localparam int COLOUR_BLKS = 6;
  localparam int BLK_IDX_W   = $clog2(COLOUR_BLKS);

  typedef enum logic [1:0] {
    FMT_4BPP  = 2'd0,
    FMT_8BPP  = 2'd1,
    FMT_15BPP = 2'd2,
    FMT_24BPP = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    SEL_CR   = 2'd0,
    SEL_CB   = 2'd1,
    SEL_LUMA = 2'd2
  } wrSel_e;

  typedef enum logic {
    ST_FILL  = 1'b0,
    ST_DRAIN = 1'b1
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 wrEn;
    wrSel_e               wrSel;
    logic [1:0]           quad;
    logic [BLK_SMP_W-1:0] smp;
    logic                 colour;
    logic [PIX_W-1:0]     pix;
  } dpCtrl_t;

endpackage

// File: rtl/mbCtrl.sv
module mbCtrl
  import mbPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] fmtSel,
  input  logic       inValid,
  input  logic       inFirst,
  output logic       inReady,
  output logic       outValid,
  input  logic       outReady,
  output logic       outLast,
  output dpCtrl_t    dpc
);

  localparam logic [BLK_IDX_W-1:0] LAST_BLK  = BLK_IDX_W'(COLOUR_BLKS - 1);
  localparam logic [PIX_W-1:0]     MONO_LAST = PIX_W'(BLK_SAMPLES - 1);
  localparam logic [PIX_W-1:0]     COL_LAST  = PIX_W'(MB_PIXELS - 1);

  state_e               state;
  logic [BLK_IDX_W-1:0] blkIdx;
  logic [BLK_SMP_W-1:0] smpIdx;
  logic [PIX_W-1:0]     pixIdx;
  logic                 modeColour;

  logic                 fmtColour;
  logic                 fill;
  logic                 atMbStart;
  logic                 colourNow;
  logic [BLK_SMP_W-1:0] effSmp;
  logic                 accept;
  logic                 blkDone;
  logic                 mbDone;
  logic                 deliver;
  logic                 lastPix;

  always_comb begin
    fmtColour = (fmt_e'(fmtSel) == FMT_15BPP) || (fmt_e'(fmtSel) == FMT_24BPP);
    fill      = (state == ST_FILL);
    atMbStart = fill && (blkIdx == '0) && ((smpIdx == '0) || inFirst);
    colourNow = atMbStart ? fmtColour : modeColour;
    effSmp    = inFirst ? '0 : smpIdx;
    accept    = inValid && fill;
    blkDone   = (effSmp == '1);
    mbDone    = blkDone && (!colourNow || (blkIdx == LAST_BLK));
    lastPix   = colourNow ? (pixIdx == COL_LAST) : (pixIdx == MONO_LAST);
  end

  assign inReady  = fill;
  assign outValid = (state == ST_DRAIN);
  assign outLast  = outValid && lastPix;
  assign deliver  = outValid && outReady;

  // write target selection
  always_comb begin
    dpc        = '0;
    dpc.wrEn   = accept;
    dpc.smp    = effSmp;
    dpc.colour = colourNow;
    dpc.pix    = pixIdx;
    if (!colourNow) begin
      dpc.wrSel = SEL_LUMA;
      dpc.quad  = 2'd0;
    end else if (blkIdx == BLK_IDX_W'(0)) begin
      dpc.wrSel = SEL_CR;
      dpc.quad  = 2'd0;
    end else if (blkIdx == BLK_IDX_W'(1)) begin
      dpc.wrSel = SEL_CB;
      dpc.quad  = 2'd0;
    end else begin
      dpc.wrSel = SEL_LUMA;
      dpc.quad  = 2'(blkIdx - BLK_IDX_W'(2));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_FILL;
      blkIdx     <= '0;
      smpIdx     <= '0;
      pixIdx     <= '0;
      modeColour <= 1'b0;
    end else begin
      if (accept) begin
        if (atMbStart) modeColour <= fmtColour;
        if (blkDone) begin
          smpIdx <= '0;
          if (mbDone) begin
            state  <= ST_DRAIN;
            pixIdx <= '0;
          end else begin
            blkIdx <= blkIdx + 1'b1;
          end
        end else begin
          smpIdx <= effSmp + 1'b1;
        end
      end
      if (deliver) begin
        if (lastPix) begin
          state  <= ST_FILL;
          blkIdx <= '0;
          smpIdx <= '0;
        end else begin
          pixIdx <= pixIdx + 1'b1;
        end
      end
    end
  end

  AST_HOLD_PIXEL: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(pixIdx)))
    else $error("pixel moved without handshake"); // R8

  AST_RETURN_TO_FILL: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && outLast) |=> (inReady && (blkIdx == '0) && (smpIdx == '0)))
    else $error("no return to fill after last pixel"); // R8

  AST_DRAIN_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> (pixIdx == '0))
    else $error("drain did not start at pixel 0"); // R3

  AST_DRAIN_AFTER_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> $past(inValid && inReady && !inFirst && (smpIdx == '1)))
    else $error("drain started before block end"); // R3

  AST_MONO_ONE_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (blkIdx != '0) |-> modeColour)
    else $error("block index advanced in monochrome"); // R6

endmodule

// File: rtl/mbDatapath.sv
module mbDatapath
  import mbPkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  dpCtrl_t             dpc,
  input  logic [SAMPLE_W-1:0] inData,
  output logic [SAMPLE_W-1:0] outY,
  output logic [SAMPLE_W-1:0] outCb,
  output logic [SAMPLE_W-1:0] outCr
);

  localparam int N_CHROMA = 2;

  logic [SAMPLE_W-1:0]  lumaMem [MB_PIXELS];
  logic [PIX_W-1:0]     lumaWrAddr;
  logic [BLK_SMP_W-1:0] chromaRdAddr;
  logic [SAMPLE_W-1:0]  chromaRd [N_CHROMA];

  // luma is stored in raster order so the drain is a plain counter
  always_comb begin
    if (dpc.colour)
      lumaWrAddr = {dpc.quad[1], dpc.smp[BLK_SMP_W-1:LOG_BLK],
                    dpc.quad[0], dpc.smp[LOG_BLK-1:0]};
    else
      lumaWrAddr = PIX_W'(dpc.smp);
  end

  always_ff @(posedge clk) begin
    if (dpc.wrEn && (dpc.wrSel == SEL_LUMA)) lumaMem[lumaWrAddr] <= inData;
  end

  // half-resolution chroma: drop the low bit of row and column
  assign chromaRdAddr = {dpc.pix[PIX_W-1:LOG_BLK+2], dpc.pix[LOG_BLK:1]};

  for (genvar p = 0; p < N_CHROMA; p++) begin : gPlane
    localparam wrSel_e PLANE_SEL = (p == 0) ? SEL_CR : SEL_CB;
    logic [SAMPLE_W-1:0] planeMem [BLK_SAMPLES];

    always_ff @(posedge clk) begin
      if (dpc.wrEn && (dpc.wrSel == PLANE_SEL)) planeMem[dpc.smp] <= inData;
    end

    assign chromaRd[p] = dpc.colour ? planeMem[chromaRdAddr] : '0;
  end

  assign outY  = lumaMem[dpc.pix];
  assign outCr = chromaRd[0];
  assign outCb = chromaRd[1];

  AST_CHROMA_ONLY_COLOUR: assert property (@(posedge clk) disable iff (rst)
    (dpc.wrEn && (dpc.wrSel != SEL_LUMA)) |-> dpc.colour)
    else $error("chroma write in monochrome mode"); // R6

  AST_MONO_QUAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dpc.wrEn && !dpc.colour) |-> (dpc.quad == 2'd0))
    else $error("monochrome write outside first quadrant"); // R6

endmodule

// File: rtl/mbAssembler.sv
module mbAssembler
  import mbPkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          fmtSel,
  input  logic                inValid,
  output logic                inReady,
  input  logic                inFirst,
  input  logic [SAMPLE_W-1:0] inData,
  output logic                outValid,
  input  logic                outReady,
  output logic                outLast,
  output logic [SAMPLE_W-1:0] outY,
  output logic [SAMPLE_W-1:0] outCb,
  output logic [SAMPLE_W-1:0] outCr
);

  dpCtrl_t dpc;

  mbCtrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .fmtSel   (fmtSel),
    .inValid  (inValid),
    .inFirst  (inFirst),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .outLast  (outLast),
    .dpc      (dpc)
  );

  mbDatapath #(.SAMPLE_W(SAMPLE_W)) uDp (
    .clk    (clk),
    .rst    (rst),
    .dpc    (dpc),
    .inData (inData),
    .outY   (outY),
    .outCb  (outCb),
    .outCr  (outCr)
  );

endmodule

// File: tb/tb_mbAssembler.sv
module tb_mbAssembler;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  // vector: {fmtSel[1:0], seed[7:0], stall[1:0]}
  localparam int NVEC = 6;
  localparam logic [11:0] VEC [NVEC] = '{
    {2'd3, 8'h11, 2'd0},
    {2'd0, 8'h23, 2'd0},
    {2'd2, 8'h5a, 2'd1},
    {2'd1, 8'h7e, 2'd2},
    {2'd3, 8'hc4, 2'd3},
    {2'd1, 8'h09, 2'd1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] fmtSel = 2'd0;
  logic       inValid = 1'b0;
  logic       inFirst = 1'b0;
  logic [7:0] inData = '0;
  logic       outReady = 1'b0;
  logic       inReady, outValid, outLast;
  logic [7:0] outY, outCb, outCr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbAssembler dut (
    .clk(clk), .rst(rst), .fmtSel(fmtSel),
    .inValid(inValid), .inReady(inReady), .inFirst(inFirst), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outLast(outLast),
    .outY(outY), .outCb(outCb), .outCr(outCr)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R8: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [7:0] val(int seed, int b, int s);
    return 8'(seed * 7 + b * 37 + s * 3 + (s / 8) * 11 + 1);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pushSample(logic [7:0] d, bit f);
    inData  = d;
    inFirst = f;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    inFirst = 1'b0;
  endtask

  // fill one macroblock; swap flips the mode after the first sample (R2)
  task automatic fillMb(logic [1:0] fmt, int seed, bit swap);
    int nb = fmt[1] ? 6 : 1;
    fmtSel = fmt;
    for (int b = 0; b < nb; b++)
      for (int s = 0; s < 64; s++) begin
        if (b == nb - 1 && s == 63)
          check(outValid == 1'b0, "R3", "outValid before last sample", outValid, 0);
        pushSample(val(seed, b, s), 1'b0);
        if (swap && b == 0 && s == 0) fmtSel = ~fmt;
      end
    check(inReady == 1'b0 && outValid == 1'b1, "R3", "ready/valid after fill",
          {inReady, outValid}, 2'b01);
  endtask

  task automatic drainMb(bit colour, int seed, int stall);
    int n = colour ? 256 : 64;
    for (int p = 0; p < n; p++) begin
      logic [7:0] ey, ecb, ecr;
      int x, y, q, s, c;
      outReady = 1'b0;
      repeat (stall) @(negedge clk);
      outReady = 1'b1;
      while (!outValid) @(negedge clk);
      if (colour) begin
        y = p / 16; x = p % 16;
        q = (y / 8) * 2 + (x / 8);
        s = (y % 8) * 8 + (x % 8);
        c = (y / 2) * 8 + (x / 2);
        ey = val(seed, 2 + q, s); ecr = val(seed, 0, c); ecb = val(seed, 1, c);
      end else begin
        ey = val(seed, 0, p); ecb = '0; ecr = '0;
      end
      check({outY, outCb, outCr, outLast} == {ey, ecb, ecr, (p == n - 1)},
            colour ? "R4 R5 R7" : "R6 R7", $sformatf("pixel %0d {y,cb,cr,last}", p),
            {outY, outCb, outCr, outLast}, {ey, ecb, ecr, p == n - 1});
      @(negedge clk);
      outReady = 1'b0;
    end
    check(inReady == 1'b1 && outValid == 1'b0, "R8", "ready after last pixel",
          {inReady, outValid}, 2'b10);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(inReady == 1'b1 && outValid == 1'b0 && outLast == 1'b0, "R1", "reset state",
          {inReady, outValid, outLast}, 3'b100);

    // table walk: first entry is colour right after reset, first block is Cr (R1)
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] f = VEC[i][11:10];
      int sd = int'(VEC[i][9:2]);
      int st = int'(VEC[i][1:0]);
      fillMb(f, sd, 1'b0);
      drainMb(f[1], sd, st);
    end

    // R2: mode change after the first sample is ignored
    fillMb(2'd3, 8'h31, 1'b1);
    drainMb(1'b1, 8'h31, 0);
    fillMb(2'd0, 8'h42, 1'b1);
    drainMb(1'b0, 8'h42, 0);

    // R8: outputs hold while outReady is low
    fillMb(2'd2, 8'h17, 1'b0);
    begin
      logic [25:0] snap;
      bit stable = 1'b1;
      outReady = 1'b0;
      snap = {outValid, outLast, outY, outCb, outCr};
      repeat (5) begin
        @(negedge clk);
        if ({outValid, outLast, outY, outCb, outCr} != snap) stable = 1'b0;
      end
      check(stable, "R8", "hold under back-pressure",
            {outValid, outY, outCb, outCr}, snap[25:0]);
    end
    drainMb(1'b1, 8'h17, 0);

    // R9: inFirst realigns the block, mono
    fmtSel = 2'd1;
    for (int s = 0; s < 10; s++) pushSample(val(8'h99, 0, s), 1'b0);
    for (int s = 0; s < 64; s++) pushSample(val(8'h50, 0, s), s == 0);
    check(outValid == 1'b1, "R9", "valid after realigned block", outValid, 1);
    drainMb(1'b0, 8'h50, 0);

    // R9 in colour: realign inside the Cb block
    fmtSel = 2'd3;
    for (int s = 0; s < 64; s++) pushSample(val(8'h66, 0, s), 1'b0);
    for (int s = 0; s < 20; s++) pushSample(8'hee, 1'b0);
    for (int b = 1; b < 6; b++)
      for (int s = 0; s < 64; s++) pushSample(val(8'h66, b, s), b == 1 && s == 0);
    drainMb(1'b1, 8'h66, 0);

    // R10: reset in the middle of a colour macroblock
    fmtSel = 2'd3;
    for (int s = 0; s < 100; s++) pushSample(8'h5c, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(inReady == 1'b1 && outValid == 1'b0, "R10", "state after mid reset",
          {inReady, outValid}, 2'b10);
    fillMb(2'd0, 8'h60, 1'b0);
    drainMb(1'b0, 8'h60, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule